// File: doc/BRIEF.md
# Time Slot Interchange Switch Core

This block is a non-blocking time slot interchanger for four serial receive lanes and four serial transmit lanes. Each lane carries a frame of 32 eight-bit slots, so 128 slots arrive and 128 leave per frame. The core clock is the bit clock: one serial bit moves per clock on every lane, and a frame lasts 256 clocks. A frame-sync input marks the first bit of slot 0. Every received byte is stored in a data memory that is double-buffered by frame.

Each transmit slot has a 16-bit connection entry. In switched mode, the entry names the stored input byte to resend. In constant mode, the entry supplies a byte written by the processor, which is sent every frame. The entry also holds a per-slot drive enable. A master enable input can force all lanes to high impedance at once.

The byte for each slot is fetched at the last clock of the slot before it. A processor port writes and reads the connection entries.

Top module: `tsi_switch`

## Requirements
- R1: When `framePulse` is high, that clock is bit 0 of slot 0 on every lane. Every lane then moves one bit per clock, MSB first, 8 bits per slot and 32 slots per frame. The slot count advances by one after every eighth bit.
- R2: A received byte is stored at data address {lane[1:0], slot[4:0]}. A transmit slot in switched mode (entry bit 9 = 0) sends, in frame F, the byte received in frame F-1 at the address in entry bits 6:0. This one-frame delay also applies when the source and destination share a slot position, and when the source is slot 31.
- R3: Several transmit slots on different lanes may name the same source address, and each of them sends that byte.
- R4: A transmit slot in constant mode (entry bit 9 = 1) sends entry bits 7:0 in every frame until that entry is rewritten.
- R5: A slot's byte and enable are sampled at the last clock of the previous slot. A write at that clock or later in the slot changes the output only from the next frame. A write at an earlier clock takes effect in the current frame.
- R6: With `masterOe` high, `txOe` of a lane is high for the whole slot exactly when entry bit 8 of that slot is 1. `txOe` does not change inside a slot.
- R7: With `masterOe` low, all `txOe` bits are low in the same clock, whatever the entries hold.
- R8: After reset, all entries and all stored bytes are zero. All `txOe` bits are low, and switched slots send zero bytes during the first frame.
- R9: `cpuRData` shows, in the same clock, the full 16-bit entry at `cpuAddr`, including the unused bits 15:10. A write with `cpuWe` high lands at the clock edge.
- R10: In switched mode, entry bit 7 plays no part in the source address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| framePulse | input | 1 | High during bit 0 of slot 0 |
| rxData | input | 4 | One serial receive bit per lane |
| txData | output | 4 | One serial transmit bit per lane |
| txOe | output | 4 | Per-lane drive enable for the current bit |
| masterOe | input | 1 | Master enable; low forces every txOe low |
| cpuWe | input | 1 | Write strobe for a connection entry |
| cpuAddr | input | 7 | Entry address {lane[1:0], slot[4:0]} |
| cpuWData | input | 16 | Entry write data |
| cpuRData | output | 16 | Entry read data at cpuAddr |

## Verification
A serial bit or enable takes effect one clock after the edge that loads its slot, and that edge is the last clock of the previous slot. The reference model therefore computes each lane's expected byte at that same edge, from the entries as they stood before any write at that edge. It then compares one bit per clock on the falling edge. Switched data is due one full frame after reception, so the model indexes its generated input bytes by frame minus one. Entry readback and the master enable respond within the same clock, so both are compared on the falling edge of the cycle in which they are driven.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int STREAMS  = 4;
  localparam int CHANS    = 32;
  localparam int BYTE_W   = 8;
  localparam int STREAM_W = $clog2(STREAMS);
  localparam int CHAN_W   = $clog2(CHANS);
  localparam int BIT_W    = $clog2(BYTE_W);
  localparam int ADDR_W   = STREAM_W + CHAN_W;
  localparam int POS_W    = CHAN_W + BIT_W;
  localparam int CONN_W   = 2 * BYTE_W;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int EN_BIT   = 0;  // bit within the high byte: drive enable
  localparam int MODE_BIT = 1;  // bit within the high byte: constant mode

  typedef struct packed {
    logic              byteDone;  // last bit of a slot
    logic [CHAN_W-1:0] rxChan;    // slot being received
    logic [CHAN_W-1:0] nextChan;  // slot being fetched for transmit
    logic              wrBuf;     // data buffer written this frame
    logic              rdBuf;     // data buffer read by the fetch
    logic              fwdLast;   // fetch targets slot 0 of next frame
  } tsi_strobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        framePulse,
  output tsi_strobe_t strobe
);
  logic [POS_W-1:0] posReg;
  logic [POS_W-1:0] curPos;
  logic             parity;
  logic             lastSlot;

  always_comb curPos = framePulse ? '0 : posReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posReg <= '0;
      parity <= 1'b0;
    end else begin
      posReg <= curPos + POS_W'(1);
      if (&curPos) parity <= ~parity;
    end
  end

  always_comb begin
    lastSlot        = &curPos[POS_W-1:BIT_W];
    strobe.byteDone = &curPos[BIT_W-1:0];
    strobe.rxChan   = curPos[POS_W-1:BIT_W];
    strobe.nextChan = curPos[POS_W-1:BIT_W] + CHAN_W'(1);
    strobe.wrBuf    = parity;
    // slot 0 of the next frame reads the buffer still being filled
    strobe.rdBuf    = lastSlot ? parity : ~parity;
    strobe.fwdLast  = lastSlot;
  end
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tsi_strobe_t        strobe,
  input  logic [STREAMS-1:0] rxData,
  input  logic               masterOe,
  input  logic               cpuWe,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [CONN_W-1:0]  cpuWData,
  output logic [CONN_W-1:0]  cpuRData,
  output logic [STREAMS-1:0] txData,
  output logic [STREAMS-1:0] txOe
);
  logic [BYTE_W-1:0] dataMem [2][DEPTH];
  logic [CONN_W-1:0] connMem [DEPTH];
  logic [STREAMS-1:0][BYTE_W-1:0] rxByte;

  assign cpuRData = connMem[cpuAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) connMem[a] <= '0;
    end else if (cpuWe) begin
      connMem[cpuAddr] <= cpuWData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < DEPTH; a++) dataMem[b][a] <= '0;
    end else if (strobe.byteDone) begin
      for (int s = 0; s < STREAMS; s++)
        dataMem[strobe.wrBuf][{STREAM_W'(s), strobe.rxChan}] <= rxByte[s];
    end
  end

  for (genvar s = 0; s < STREAMS; s++) begin : gLane
    logic [BYTE_W-1:0]   rxShift;
    logic [BYTE_W-1:0]   txShift;
    logic                txEnReg;
    logic [ADDR_W-1:0]   entryAddr;
    logic [BYTE_W-1:0]   lowByte;
    logic                enBit;
    logic                modeBit;
    logic [ADDR_W-1:0]   srcAddr;
    logic [STREAM_W-1:0] srcLane;
    logic [BYTE_W-1:0]   memByte;
    logic [BYTE_W-1:0]   fetched;

    assign rxByte[s] = {rxShift[BYTE_W-2:0], rxData[s]};

    always_comb begin
      entryAddr = {STREAM_W'(s), strobe.nextChan};
      lowByte   = connMem[entryAddr][BYTE_W-1:0];
      enBit     = connMem[entryAddr][BYTE_W+EN_BIT];
      modeBit   = connMem[entryAddr][BYTE_W+MODE_BIT];
      srcAddr   = lowByte[ADDR_W-1:0];
      srcLane   = srcAddr[ADDR_W-1:CHAN_W];
      if (strobe.fwdLast && (&srcAddr[CHAN_W-1:0]))
        memByte = rxByte[srcLane];  // slot 31 completes at this very edge
      else
        memByte = dataMem[strobe.rdBuf][srcAddr];
      fetched = modeBit ? lowByte : memByte;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxShift <= '0;
        txShift <= '0;
        txEnReg <= 1'b0;
      end else begin
        rxShift <= rxByte[s];
        if (strobe.byteDone) begin
          txShift <= fetched;
          txEnReg <= enBit;
        end else begin
          txShift <= {txShift[BYTE_W-2:0], 1'b0};
        end
      end
    end

    assign txData[s] = txShift[BYTE_W-1];
    assign txOe[s]   = masterOe & txEnReg;
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               framePulse,
  input  logic [STREAMS-1:0] rxData,
  output logic [STREAMS-1:0] txData,
  output logic [STREAMS-1:0] txOe,
  input  logic               masterOe,
  input  logic               cpuWe,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [CONN_W-1:0]  cpuWData,
  output logic [CONN_W-1:0]  cpuRData
);
  tsi_strobe_t strobe;

  tsi_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .strobe     (strobe)
  );

  tsi_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rxData   (rxData),
    .masterOe (masterOe),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWData (cpuWData),
    .cpuRData (cpuRData),
    .txData   (txData),
    .txOe     (txOe)
  );
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker
  import tsi_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               framePulse,
  input logic               masterOe,
  input logic               cpuWe,
  input logic [ADDR_W-1:0]  cpuAddr,
  input logic [CONN_W-1:0]  cpuWData,
  input logic [CONN_W-1:0]  cpuRData,
  input logic [STREAMS-1:0] txOe,
  input tsi_strobe_t        strobe
);
  // R1: slot count steps by one after each completed byte
  assert_chan_advance_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.byteDone && !framePulse) |=>
      (framePulse || strobe.rxChan == $past(strobe.rxChan) + CHAN_W'(1)));

  // R6: enables only change at a slot boundary
  assert_oe_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.byteDone) && masterOe && $past(masterOe)) |-> $stable(txOe));

  // R7: master enable low silences every lane
  assert_master_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !masterOe |-> (txOe == '0));

  // R9: a written entry reads back at the following clock
  assert_readback_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuWe |=> ((cpuAddr != $past(cpuAddr)) || (cpuRData == $past(cpuWData))));
endmodule

bind tsi_switch tsi_checker chk (
  .clk        (clk),
  .rstN       (rstN),
  .framePulse (framePulse),
  .masterOe   (masterOe),
  .cpuWe      (cpuWe),
  .cpuAddr    (cpuAddr),
  .cpuWData   (cpuWData),
  .cpuRData   (cpuRData),
  .txOe       (txOe),
  .strobe     (strobe)
);

// File: tb/tb_tsi_switch.sv
`timescale 1ns/1ps
module tb_tsi_switch;
  import tsi_pkg::*;

  localparam int NCYC = 6 * 256;

  logic        clk = 1'b0;
  logic        rstN;
  logic        framePulse;
  logic [3:0]  rxData;
  logic [3:0]  txData;
  logic [3:0]  txOe;
  logic        masterOe;
  logic        cpuWe;
  logic [6:0]  cpuAddr;
  logic [15:0] cpuWData;
  logic [15:0] cpuRData;

  always #2.5 clk = ~clk;

  tsi_switch dut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .rxData(rxData),
    .txData(txData), .txOe(txOe), .masterOe(masterOe), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWData(cpuWData), .cpuRData(cpuRData)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  logic [15:0] cm [128];
  logic [7:0]  expByte [4];
  logic        expEn [4];
  string       expTag [4];

  function automatic logic [7:0] inByte(int f, int a);
    return 8'((f * 37 + a * 11 + 5) % 256);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string chanTag(int s, int t);
    if (s == 0 && t == 0) return "R2";   // source is slot 31, forwarded
    if (s == 0 && t == 20) return "R10";
    if (s == 1 && t == 9) return "R2";   // same slot position
    if ((s == 1 && t == 0) || (s == 2 && t == 31) || (s == 3 && t == 10)) return "R3";
    if (s == 3 && t == 4) return "R5";
    return "R1";
  endfunction

  task automatic wr(int s, int c, logic [15:0] d);
    cpuWe    = 1'b1;
    cpuAddr  = 7'(s * 32 + c);
    cpuWData = d;
  endtask

  task automatic setInputs(int n);
    int pos = n % 256;
    int f   = n / 256;
    framePulse = (pos == 0);
    for (int s = 0; s < 4; s++) begin
      logic [7:0] b = inByte(f, s * 32 + pos / 8);
      rxData[s] = b[7 - pos % 8];
    end
    cpuWe    = 1'b0;
    cpuAddr  = 7'(n);
    cpuWData = '0;
    case (n)
      1:   wr(0, 5,  16'h0151);
      2:   wr(1, 0,  16'h0163);
      3:   wr(2, 31, 16'h0163);
      4:   wr(3, 10, 16'h0163);
      5:   wr(3, 4,  16'h03A5);
      6:   wr(1, 9,  16'h0129);
      7:   wr(0, 0,  16'h017F);
      8:   wr(2, 2,  16'h023C);
      9:   wr(0, 20, 16'hF58C);
      10:  wr(1, 15, 16'h012F);
      543: wr(3, 4,  16'h035A);  // on the fetch edge of slot 4
      798: wr(3, 4,  16'h03C3);  // one clock before that fetch edge
      868: wr(1, 9,  16'h0029);
      default: ;
    endcase
    masterOe = !(n >= 1100 && n < 1180);
  endtask

  task automatic modelEdge(int n);
    int pos = n % 256;
    int f   = n / 256;
    if (pos % 8 == 7) begin
      int t  = (pos / 8 + 1) % 32;
      int tf = (t == 0) ? f + 1 : f;
      for (int s = 0; s < 4; s++) begin
        logic [15:0] e = cm[s * 32 + t];
        expEn[s] = e[8];
        if (e[9]) begin
          expByte[s] = e[7:0];
          expTag[s]  = (s == 3 && t == 4) ? "R5" : "R4";
        end else if (tf == 0) begin
          expByte[s] = 8'h00;
          expTag[s]  = "R8";
        end else begin
          expByte[s] = inByte(tf - 1, int'(e[6:0]));
          expTag[s]  = chanTag(s, t);
        end
      end
    end else begin
      for (int s = 0; s < 4; s++) expByte[s] = {expByte[s][6:0], 1'b0};
    end
    if (cpuWe) cm[cpuAddr] = cpuWData;
  endtask

  task automatic checkOutputs(int n);
    for (int s = 0; s < 4; s++) begin
      check(txData[s] == expByte[s][7], expTag[s],
            $sformatf("txData lane %0d cycle %0d", s, n), int'(txData[s]), int'(expByte[s][7]));
      check(txOe[s] == (masterOe & expEn[s]), masterOe ? "R6" : "R7",
            $sformatf("txOe lane %0d cycle %0d", s, n), int'(txOe[s]), int'(masterOe & expEn[s]));
    end
    check(cpuRData == cm[cpuAddr], "R9", $sformatf("cpuRData addr %0d", cpuAddr),
          int'(cpuRData), int'(cm[cpuAddr]));
  endtask

  initial begin
    for (int a = 0; a < 128; a++) cm[a] = '0;
    for (int s = 0; s < 4; s++) begin
      expByte[s] = '0;
      expEn[s]   = 1'b0;
      expTag[s]  = "R8";
    end
    rstN = 1'b0;
    framePulse = 1'b0; rxData = '0; masterOe = 1'b1;
    cpuWe = 1'b0; cpuAddr = '0; cpuWData = '0;
    repeat (3) @(negedge clk);
    check(txOe == 4'h0, "R8", "txOe in reset", int'(txOe), 0);
    check(cpuRData == 16'h0, "R8", "entry 0 in reset", int'(cpuRData), 0);
    setInputs(0);
    rstN = 1'b1;
    for (int n = 0; n < NCYC; n++) begin
      @(posedge clk);
      modelEdge(n);
      @(negedge clk);
      checkOutputs(n);
      setInputs(n + 1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule